// File: doc/BRIEF.md
# Dual-Edge Testable Reversible Flip-Flop

This block stores one data bit on both the rising and the falling edge of its clock, so a single clock period carries two data values. Moving the same data rate therefore needs only half the clock frequency of a single-edge register. The storage is split across two level-sensitive latches built from controlled-controlled-NOT (CCNOT) cells. The high-transparent latch is open while the clock is high and closes on the falling edge. The low-transparent latch is open while the clock is low and closes on the rising edge. A fifth CCNOT cell, wired as a 2:1 selector driven by the clock, always forwards the latch that is currently holding.

Each latch has its own two-bit test control. It can pass its stored bit through, or force a constant 0 or 1, so that each half of the storage path can be checked on its own. Each latch's tested value is also brought out on an observation pin, and those pins can be gated to zero.

Top module: `dual_edge_rev_ff`

## Requirements
- R1: In normal mode (both control pairs 2'b01), while clk is high, q equals the value d had at the most recent rising edge.
- R2: In normal mode, while clk is low, q equals the value d had at the most recent falling edge.
- R3: In normal mode, changes of d between two clock edges do not reach q before the next edge.
- R4: When d alternates at every edge, q takes a new value at every edge, giving two distinct samples per clock period.
- R5: Each control pair `{first, second}` selects a mode: 2'b01 passes that latch's stored bit (2'b10 behaves the same), 2'b00 forces its output to 0, and 2'b11 forces it to 1. With both pairs at 2'b00, q stays 0 whatever d and clk do.
- R6: With both control pairs at 2'b11, q stays 1 whatever d and clk do.
- R7: The two control pairs act independently. With hi_mode=2'b00 and lo_mode=2'b01, q is 0 while clk is low and is the rising-edge sample while clk is high. With hi_mode=2'b11, q is 1 while clk is low.
- R8: When obs_en is 1, obs_hi shows the tested output of the high-transparent latch and obs_lo shows that of the low-transparent latch. When obs_en is 0, both are 0, and q is unaffected by obs_en.
- R9: While rst_n is low, both latches are cleared, so in normal mode q, obs_hi and obs_lo are 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; both edges sample d |
| rst_n | input | 1 | Asynchronous active-low clear of both latches |
| d | input | 1 | Data in |
| hi_mode | input | 2 | Test control of the high-transparent latch, {first, second} |
| lo_mode | input | 2 | Test control of the low-transparent latch, {first, second} |
| obs_en | input | 1 | Enables the observation outputs |
| q | output | 1 | Data out, the last sample of either edge |
| obs_hi | output | 1 | Tested output of the high-transparent latch, gated by obs_en |
| obs_lo | output | 1 | Tested output of the low-transparent latch, gated by obs_en |

## Verification
The bench drives d in the middle of each half period and compares q against a reference that records d at every edge of either polarity. Sampling just after each edge and again just before the next catches a selector wired to the transparent latch instead of the holding one: such a design would let mid-phase changes of d leak to q. An alternating data pattern exposes a design that captures on one edge only, because q would then change once per period instead of twice. Mixed test modes, with one latch forced and the other normal, reveal swapped control pairs or swapped constants, since q then shows the wrong constant in the wrong clock phase. Turning the observation gate off while checking q catches gating placed on the data path.

// File: rtl/dual_edge_rev_ff.sv
module dual_edge_rev_ff (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       d,
  input  logic [1:0] hi_mode,
  input  logic [1:0] lo_mode,
  input  logic       obs_en,
  output logic       q,
  output logic       obs_hi,
  output logic       obs_lo
);

  function automatic logic ccnot(input logic c0, input logic c1, input logic tgt);
    return tgt ^ (c0 & c1);
  endfunction

  logic hi_take, lo_take;
  logic hi_st, lo_st;
  logic hi_force, lo_force, hi_pass, lo_pass;
  logic hi_out, lo_out;
  logic sel_lo_part;

  // cell 1 of each latch: gated capture of d
  assign hi_take = ccnot(clk, d, 1'b0);
  assign lo_take = ccnot(!clk, d, 1'b0);

  always_latch begin
    if (!rst_n)   hi_st <= 1'b0;
    else if (clk) hi_st <= hi_take;
  end

  always_latch begin
    if (!rst_n)    lo_st <= 1'b0;
    else if (!clk) lo_st <= lo_take;
  end

  // cell 2 of each latch: test stage
  assign hi_force = ccnot(hi_mode[1], hi_mode[0], 1'b0);
  assign hi_pass  = hi_mode[1] ^ hi_mode[0];
  assign hi_out   = ccnot(hi_st, hi_pass, hi_force);

  assign lo_force = ccnot(lo_mode[1], lo_mode[0], 1'b0);
  assign lo_pass  = lo_mode[1] ^ lo_mode[0];
  assign lo_out   = ccnot(lo_st, lo_pass, lo_force);

  // cell 5: selector forwarding the holding latch
  assign sel_lo_part = ccnot(!clk, hi_out, 1'b0);
  assign q           = ccnot(clk, lo_out, sel_lo_part);

  assign obs_hi = ccnot(obs_en, hi_out, 1'b0);
  assign obs_lo = ccnot(obs_en, lo_out, 1'b0);

  logic normal;
  assign normal = (hi_mode == 2'b01) && (lo_mode == 2'b01);

  // R1: in the high phase q comes from the latch that closed at the rising edge
  a_r1_high_from_lo_latch: assert property (@(negedge clk) disable iff (!rst_n)
    normal |-> (q == lo_st));

  // R2: in the low phase q comes from the latch that closed at the falling edge
  a_r2_low_from_hi_latch: assert property (@(posedge clk) disable iff (!rst_n)
    normal |-> (q == hi_st));

  a_r5_all_zero_mode: assert property (@(posedge clk) disable iff (!rst_n)
    (hi_mode == 2'b00 && lo_mode == 2'b00) |-> (q == 1'b0));

  a_r6_all_one_mode: assert property (@(negedge clk) disable iff (!rst_n)
    (hi_mode == 2'b11 && lo_mode == 2'b11) |-> (q == 1'b1));

  a_r8_obs_gated: assert property (@(posedge clk) disable iff (!rst_n)
    !obs_en |-> (!obs_hi && !obs_lo));

endmodule

// File: tb/test_dual_edge_rev_ff.sv
`timescale 1ns/1ps
module test_dual_edge_rev_ff;
  logic clk, rst_n, d, obs_en;
  logic [1:0] hi_mode, lo_mode;
  logic q, obs_hi, obs_lo;
  int n_chk = 0, n_err = 0;
  logic done = 1'b0;

  dual_edge_rev_ff i_dual_edge_rev_ff (
    .clk(clk), .rst_n(rst_n), .d(d), .hi_mode(hi_mode), .lo_mode(lo_mode),
    .obs_en(obs_en), .q(q), .obs_hi(obs_hi), .obs_lo(obs_lo));

  initial clk = 1'b0;
  always #10 clk = ~clk;

  task automatic chk(input string req, input logic act, input logic exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s: actual=%b expected=%b at %0t", req, act, exp, $time);
    end
  endtask

  // waits for an edge of either polarity, returns its polarity and the d it saw
  task automatic next_edge(output logic rise, output logic smp);
    @(posedge clk or negedge clk);
    rise = clk;
    smp = d;
    #3;
  endtask

  task automatic drive(input logic nd);
    #3 d = nd;
    #2;
  endtask

  task automatic t_reset();
    rst_n = 1'b0; d = 1'b1; hi_mode = 2'b01; lo_mode = 2'b01; obs_en = 1'b1;
    #15;
    chk("R9 q under reset", q, 1'b0);
    chk("R9 obs_hi under reset", obs_hi, 1'b0);
    chk("R9 obs_lo under reset", obs_lo, 1'b0);
    rst_n = 1'b1;
    #2;
    chk("R9 q after release before edge", q, 1'b0);
  endtask

  task automatic t_normal(input logic [15:0] pat, input string name);
    logic rise, smp;
    hi_mode = 2'b01; lo_mode = 2'b01; obs_en = 1'b1;
    for (int i = 0; i < 16; i++) begin
      next_edge(rise, smp);
      chk(rise ? "R1 rising sample" : "R2 falling sample", q, smp);
      drive(pat[i]);
      chk("R3 mid-phase d change hidden", q, smp);
    end
    $display("normal pattern %s done", name);
  endtask

  task automatic t_two_per_period();
    logic rise, smp, prev;
    hi_mode = 2'b01; lo_mode = 2'b01;
    next_edge(rise, smp);
    drive(~smp);
    prev = q;
    for (int i = 0; i < 8; i++) begin
      next_edge(rise, smp);
      chk("R4 q toggles at every edge", q, ~prev);
      prev = q;
      drive(~smp);
    end
  endtask

  task automatic t_const(input logic [1:0] m, input logic exp, input string req);
    logic rise, smp;
    hi_mode = m; lo_mode = m;
    for (int i = 0; i < 6; i++) begin
      next_edge(rise, smp);
      chk(req, q, exp);
      drive(i[0]);
      chk(req, q, exp);
    end
  endtask

  task automatic t_mixed(input logic [1:0] hm, input logic low_exp);
    logic rise, smp;
    hi_mode = hm; lo_mode = 2'b01;
    for (int i = 0; i < 8; i++) begin
      next_edge(rise, smp);
      if (rise) chk("R7 high phase rising sample", q, smp);
      else      chk("R7 low phase forced", q, low_exp);
      drive(i[1] ^ i[0]);
    end
  endtask

  task automatic t_obs();
    logic rise, smp;
    hi_mode = 2'b01; lo_mode = 2'b01; obs_en = 1'b1;
    for (int i = 0; i < 6; i++) begin
      next_edge(rise, smp);
      if (rise) chk("R8 obs_lo shows rising sample", obs_lo, smp);
      else      chk("R8 obs_hi shows falling sample", obs_hi, smp);
      drive(i[0] ^ i[2]);
    end
    obs_en = 1'b0;
    for (int i = 0; i < 6; i++) begin
      next_edge(rise, smp);
      chk("R8 q unaffected by obs_en", q, smp);
      chk("R8 obs_hi gated", obs_hi, 1'b0);
      chk("R8 obs_lo gated", obs_lo, 1'b0);
      drive(~i[0]);
    end
    obs_en = 1'b1;
  endtask

  task automatic t_reset_mid();
    logic rise, smp;
    next_edge(rise, smp);
    drive(1'b1);
    rst_n = 1'b0;
    #1;
    chk("R9 q cleared mid-run", q, 1'b0);
    chk("R9 obs_hi cleared mid-run", obs_hi, 1'b0);
    chk("R9 obs_lo cleared mid-run", obs_lo, 1'b0);
    #20;
    rst_n = 1'b1;
  endtask

  initial begin
    t_reset();
    t_normal(16'hA5C3, "a");
    t_normal(16'h00FF, "b");
    t_normal(16'hFFFF, "c");
    t_two_per_period();
    t_const(2'b00, 1'b0, "R5 all controls 00 give 0");
    t_const(2'b11, 1'b1, "R6 all controls 11 give 1");
    t_mixed(2'b00, 1'b0);
    t_mixed(2'b11, 1'b1);
    t_normal(16'h3C69, "d");
    t_obs();
    t_reset_mid();
    t_normal(16'h9117, "e");
    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        #4_000_000;
        n_chk++; n_err++;
        $display("FAIL watchdog: actual=timeout expected=completion");
      end
    join_any
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule